// File: doc/BRIEF.md
# Serial Input Frame Deframer

This block is the receiving half of a controller's serial audio link. The codec streams one frame after another over a single data line: a 16-bit tag slot, then twelve 20-bit data slots, 256 bits in all. The controller generates the frame sync itself and feeds it back to this block. The block samples the data line on every falling edge of the bit clock and places each bit in the frame by counting from the sync rising edge.

When the last bit of slot 12 has been sampled, the block publishes the frame. The tag vector goes out as received. Each slot's data is zeroed when its tag bit marks it invalid. Slot 1 carries the codec's active-low sample-request flags, and the block turns these into an active-high request vector, one bit for each output slot from 3 to 12. A single-cycle `frame_done` strobe marks each update. All outputs then hold their values until the next complete frame.

Top module: `aclink_rx_deframer`

## Requirements
- R1: The frame's bit 0 is the bit sampled on the falling edge at which `sync` is first seen high after being seen low. The next 255 falling edges supply bits 1 to 255. Every field is received MSB first.
- R2: `tag` holds frame bits 0 to 15, with frame bit 0 in `tag[15]`. Tag bit 15 is the frame-valid flag. Tag bit 15-k is the valid flag of slot k (k = 1..12).
- R3: Slot k takes the 20 frame bits that start at bit 16+20*(k-1). It is presented on `slot_data[(k-1)*20 +: 20]` with its first received bit as the MSB.
- R4: A slot whose tag valid bit is 0 is presented as all zeros, whatever data the line carried during that slot.
- R5: `slot_req[j]` (j = 0..9) is the inverse of slot 1 bit 11-j and stands for output slot j+3. The vector is decoded in every frame, whether or not slot 1 is tagged valid.
- R6: `frame_done` is high for exactly one bit-clock period, beginning at the falling edge that samples frame bit 255. The outputs change only at that edge and hold otherwise.
- R7: A new `sync` rising edge seen before bit 255 restarts the frame at bit 0. The truncated frame produces no `frame_done` and no output update.
- R8: While `rst_n` is low, all outputs are zero and no data is taken in. A `sync` that is already high when reset is released does not start a frame. After a completed frame, or after reset, the block waits for a fresh `sync` rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all sampling on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Locally generated frame sync, high for the 16 tag bits |
| sdata_in | input | 1 | Serial data from the codec, changed on rising edges |
| tag | output | 16 | Received tag slot |
| slot_data | output | 240 | Twelve 20-bit slots, slot 1 in the low bits, invalid slots zeroed |
| slot_req | output | 10 | Active-high sample requests for output slots 3 to 12 |
| frame_done | output | 1 | One-cycle strobe when a complete frame is published |

## Verification
The bench builds the block with its default parameters: twelve 20-bit slots, a 16-bit tag, and request flags in slot 1 bits 11 to 2. This is the full 256-bit frame, so the counter wrap at bit 255 is exercised. Patterns are chosen so that invalid slots carry nonzero data, the request field alternates, and a frame is cut short by an early sync. The default widths also allow a reset to be released while sync is already high.

// File: rtl/aclink_rx_deframer.sv
module aclink_rx_deframer #(
  parameter int NSLOT  = 12,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int REQ_HI = 11,
  parameter int REQ_LO = 2
) (
  input  logic                      bit_clk,
  input  logic                      rst_n,
  input  logic                      sync,
  input  logic                      sdata_in,
  output logic [TAG_W-1:0]          tag,
  output logic [NSLOT*SLOT_W-1:0]   slot_data,
  output logic [REQ_HI-REQ_LO:0]    slot_req,
  output logic                      frame_done
);
  localparam int FRAME_BITS = TAG_W + NSLOT*SLOT_W;
  localparam int CW         = $clog2(FRAME_BITS);
  localparam int REQ_N      = REQ_HI - REQ_LO + 1;

  logic                  sync_q;
  logic                  running;
  logic [CW-1:0]         cnt;
  logic [FRAME_BITS-1:0] shreg;

  wire                  start     = sync & ~sync_q;
  wire [FRAME_BITS-1:0] frame_now = {shreg[FRAME_BITS-2:0], sdata_in};
  wire                  last      = running & ~start & (cnt == CW'(FRAME_BITS-1));
  wire [TAG_W-1:0]      tag_now   = frame_now[FRAME_BITS-1 -: TAG_W];
  wire [SLOT_W-1:0]     slot1_now = frame_now[FRAME_BITS-TAG_W-1 -: SLOT_W];

  logic [NSLOT*SLOT_W-1:0] slots_now;
  logic [REQ_N-1:0]        req_now;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign slots_now[k*SLOT_W +: SLOT_W] =
      tag_now[TAG_W-2-k] ? frame_now[FRAME_BITS-TAG_W-1-k*SLOT_W -: SLOT_W] : '0;
  end

  for (genvar j = 0; j < REQ_N; j++) begin : g_req
    assign req_now[j] = ~slot1_now[REQ_HI-j];
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 1'b1;
      running    <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      tag        <= '0;
      slot_data  <= '0;
      slot_req   <= '0;
      frame_done <= 1'b0;
    end else begin
      sync_q     <= sync;
      shreg      <= frame_now;
      frame_done <= last;
      if (start) begin
        running <= 1'b1;
        cnt     <= CW'(1);
      end else if (last) begin
        running   <= 1'b0;
        cnt       <= '0;
        tag       <= tag_now;
        slot_data <= slots_now;
        slot_req  <= req_now;
      end else if (running) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r6_single_pulse: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r6_hold_outputs: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !frame_done |-> ($stable(tag) && $stable(slot_data) && $stable(slot_req)));

  a_r8_idle_after_done: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_done |-> !running);

  a_r7_start_no_done: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (sync && !sync_q) |=> !frame_done);

  for (genvar k = 0; k < NSLOT; k++) begin : g_chk
    a_r4_invalid_zero: assert property (@(negedge bit_clk) disable iff (!rst_n)
      (frame_done && !tag[TAG_W-2-k]) |-> (slot_data[k*SLOT_W +: SLOT_W] == '0));
  end
endmodule

// File: tb/sim_aclink_rx_deframer.sv
`timescale 1ns/1ps
module sim_aclink_rx_deframer;
  logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, sdi = 1'b0;
  logic [15:0]  tag;
  logic [239:0] slot_data;
  logic [9:0]   slot_req;
  logic         frame_done;
  int checks = 0, failures = 0, ndone = 0;

  always #5 clk = ~clk;

  aclink_rx_deframer u0 (.bit_clk(clk), .rst_n(rst_n), .sync(sync), .sdata_in(sdi),
    .tag(tag), .slot_data(slot_data), .slot_req(slot_req), .frame_done(frame_done));

  always @(posedge clk) if (frame_done) ndone++;

  task automatic chk(input string r, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [255:0] build(input logic [15:0] t, input logic [239:0] s);
    logic [255:0] f;
    f[255:240] = t;
    for (int k = 0; k < 12; k++) f[239-20*k -: 20] = s[20*k +: 20];
    return f;
  endfunction

  function automatic logic [239:0] exp_slots(input logic [15:0] t, input logic [239:0] s);
    logic [239:0] e;
    for (int k = 0; k < 12; k++) e[20*k +: 20] = t[14-k] ? s[20*k +: 20] : 20'h0;
    return e;
  endfunction

  function automatic logic [9:0] exp_req(input logic [239:0] s);
    logic [9:0] q;
    for (int j = 0; j < 10; j++) q[j] = ~s[11-j];
    return q;
  endfunction

  function automatic logic [239:0] pattern(input int seed);
    logic [239:0] s;
    for (int k = 0; k < 12; k++) s[20*k +: 20] = {4'(k+1+seed), 16'hA5C3 ^ 16'((k+seed)*773)};
    return s;
  endfunction

  task automatic drive(input logic [255:0] f, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk);
      sync = (i < 16);
      sdi  = f[255-i];
    end
  endtask

  task automatic frame_check(input string rs, input logic [15:0] t, input logic [239:0] s);
    drive(build(t, s), 256);
    @(posedge clk);
    sync = 1'b0; sdi = 1'b0;
    chk("R6 done strobe", 256'(frame_done), 256'(1));
    chk("R1 R2 tag", 256'(tag), 256'(t));
    chk({rs, " slot data"}, 256'(slot_data), 256'(exp_slots(t, s)));
    chk("R5 requests", 256'(slot_req), 256'(exp_req(s)));
    @(posedge clk);
    chk("R6 strobe one cycle", 256'(frame_done), 256'(0));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    chk("R8 reset tag", 256'(tag), 256'(0));
    chk("R8 reset data", 256'(slot_data), 256'(0));
    chk("R8 reset done", 256'({slot_req, frame_done}), 256'(0));
    for (int i = 0; i < 256; i++) begin
      @(posedge clk);
      if (i == 4) rst_n = 1'b1;
      sync = (i < 16);
      sdi  = i[0];
    end
    @(posedge clk); sync = 1'b0;
    repeat (4) @(posedge clk);
    #2;
    chk("R8 no frame from sync high at release", 256'(ndone), 256'(0));
    chk("R8 outputs still zero", 256'(tag), 256'(0));
  endtask

  task automatic t_valid_all;
    frame_check("R3", 16'hFFF8, pattern(0));
  endtask

  task automatic t_invalid_slots;
    logic [239:0] s = pattern(3);
    s[11:2] = 10'b1010011100;
    frame_check("R4", 16'b1010_1100_0101_1000, s);
    frame_check("R4 R5 slot1 invalid", 16'b1011_1111_1111_1000, ~240'h0 ^ {220'h0, 20'h00FFC} | pattern(5));
  endtask

  task automatic t_hold;
    int n0;
    logic [15:0] t0 = tag;
    logic [239:0] d0 = slot_data;
    logic [9:0] q0 = slot_req;
    #2 n0 = ndone;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); sync = 1'b0; sdi = ~sdi;
    end
    @(posedge clk); #2;
    chk("R6 hold tag", 256'(tag), 256'(t0));
    chk("R6 hold data", 256'(slot_data), 256'(d0));
    chk("R6 hold req", 256'(slot_req), 256'(q0));
    chk("R8 no frame without new sync", 256'(ndone), 256'(n0));
  endtask

  task automatic t_resync;
    int n0;
    logic [239:0] s = pattern(7);
    #2 n0 = ndone;
    drive(build(16'h1234, pattern(9)), 100);
    s[11:2] = 10'h0;
    frame_check("R7 R3", 16'hE7F0, s);
    #2;
    chk("R7 one done for truncated+full", 256'(ndone), 256'(n0 + 1));
  endtask

  initial begin
    t_reset;
    t_valid_all;
    t_invalid_slots;
    t_hold;
    t_resync;
    t_valid_all;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule